// File: doc/BRIEF.md
# Full-Duplex Pause Request Trigger

This block decides when a full-duplex Ethernet MAC transmitter has to emit an IEEE 802.3x pause frame, and which 16-bit pause time goes into it. It watches the receive FIFO byte count against an upper (activate) and a lower (deactivate) threshold. It also accepts a software "send now" strike, and it runs a slot-based re-check timer that refreshes the pause for as long as the FIFO stays congested.

The result is a single request/acknowledge pair towards the frame transmitter. The transmitter builds and sends the frame and then acknowledges. When a congestion episode ends, the block can release the link partner early with one zero-time pause, unless that frame is disabled. A software strike can also cancel an earlier pause by carrying a configured pause time of zero.

Top module: `fdx_pause_trig`

## Requirements
- R1: After reset, pause_req_o and sw_busy_o are 0.
- R2: While full_duplex_i or tx_fc_en_i is low, no new request is raised. In that state sw_send_i is ignored (sw_busy_o stays low) and any congestion episode is cleared.
- R3: When sw_send_i is high at an enabled clock edge, sw_busy_o is 1 after that edge. If no request is outstanding, pause_req_o rises at the next edge and carries pause_time_i sampled at that edge. A pause time of zero is carried as zero.
- R4: pause_req_o and pause_time_o stay stable until pause_ack_i is high at a clock edge. After that edge pause_req_o is 0 for at least one cycle.
- R5: sw_busy_o clears after the edge at which the request carrying the software strike is acknowledged.
- R6: When fifo_level_i is strictly greater than thr_on_i and no episode is open, a request carrying pause_time_i is raised at the next edge, and an episode opens.
- R7: Acknowledging a request with a nonzero time loads reload_i into a slot counter. The counter decrements at each edge where slot_tick_i is high. Once it reaches zero during an episode with fifo_level_i still above thr_on_i, a new request carrying pause_time_i is raised.
- R8: When fifo_level_i is strictly below thr_off_i during an episode, the episode closes. A zero-time request is raised only if zero_pause_dis_i is low. At most one zero-time request is raised per episode, and none is raised once the episode has closed.
- R9: When a software strike is pending and an automatic event occurs at the same edge, exactly one request is raised. It carries pause_time_i, and the automatic event is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_duplex_i | input | 1 | MAC operates in full duplex |
| tx_fc_en_i | input | 1 | Transmit flow control enable |
| sw_send_i | input | 1 | Software strike: send a pause now |
| sw_busy_o | output | 1 | Software strike pending until acknowledged |
| pause_time_i | input | 16 | Configured pause time |
| fifo_level_i | input | LVL_W | Receive FIFO byte count |
| thr_on_i | input | LVL_W | Activate threshold |
| thr_off_i | input | LVL_W | Deactivate threshold |
| reload_i | input | RLD_W | Re-check interval in slots |
| slot_tick_i | input | 1 | One pulse per 512 bit times |
| zero_pause_dis_i | input | 1 | Suppress the zero-time release pause |
| pause_req_o | output | 1 | Pause frame request |
| pause_time_o | output | 16 | Pause time for the requested frame |
| pause_ack_i | input | 1 | Transmitter accepted the request |

## Verification
On every cycle, the assertions check the handshake rules: the request and its time hold until they are acknowledged, and the request drops after an acknowledge. They also check that nothing new is raised while the block is disabled, that the busy flag rises only on an enabled strike and falls only on an acknowledge, and that a suppressed zero-time pause never leaks out of an automatic trigger. The exact pause time chosen when triggers coincide, the slot-counted refresh interval, and the rule of one release per episode depend on sequences of FIFO levels and acknowledges. Only the bench's directed scenarios and its cycle-level reference model under random traffic can show those.

// File: rtl/fdx_pause_pkg.sv
package fdx_pause_pkg;
  localparam int unsigned PT_W = 16;

  typedef struct packed {
    logic start;
    logic refresh;
    logic rel_z;
  } auto_ev_t;
endpackage

// File: rtl/fdx_pause_cmp.sv
module fdx_pause_cmp #(
  parameter int unsigned LVL_W = 14
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_on_i,
  input  logic [LVL_W-1:0] thr_off_i,
  output logic             over_o,
  output logic             under_o
);
  assign over_o  = level_i > thr_on_i;
  assign under_o = level_i < thr_off_i;
endmodule

// File: rtl/fdx_pause_timer.sv
module fdx_pause_timer #(
  parameter int unsigned RLD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             load_run_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             tick_i,
  output logic             expired_o
);
  logic             run_q;
  logic [RLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
    end else if (load_i) begin
      run_q <= load_run_i;
      cnt_q <= reload_i;
    end else if (tick_i && run_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && cnt_q == '0;
endmodule

// File: rtl/fdx_pause_ctrl.sv
module fdx_pause_ctrl
  import fdx_pause_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            sw_set_i,
  input  logic            ack_i,
  input  logic            over_i,
  input  logic            under_i,
  input  logic            expired_i,
  input  logic            zdis_i,
  input  logic [PT_W-1:0] pause_time_i,
  output logic            req_o,
  output logic [PT_W-1:0] req_time_o,
  output logic            sw_busy_o,
  output logic            accept_o,
  output logic            accept_nz_o
);
  logic            sw_q, req_q, req_sw_q, epi_q;
  logic [PT_W-1:0] time_q;
  auto_ev_t        ev;
  logic            fire;

  always_comb begin
    ev.start   = !epi_q && over_i;
    ev.refresh = epi_q && expired_i && over_i;
    ev.rel_z   = epi_q && under_i && !zdis_i;
  end

  assign fire        = en_i && !req_q && (sw_q || (|ev));
  assign accept_o    = req_q && ack_i;
  assign accept_nz_o = accept_o && time_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q     <= 1'b0;
      req_q    <= 1'b0;
      req_sw_q <= 1'b0;
      epi_q    <= 1'b0;
      time_q   <= '0;
    end else begin
      if (en_i && sw_set_i)          sw_q <= 1'b1;
      else if (accept_o && req_sw_q) sw_q <= 1'b0;

      if (fire) begin
        req_q    <= 1'b1;
        req_sw_q <= sw_q;
        // software strike owns the time field; auto release sends zero
        time_q   <= (sw_q || ev.start || ev.refresh) ? pause_time_i : '0;
      end else if (accept_o) begin
        req_q    <= 1'b0;
      end

      if (!en_i)                               epi_q <= 1'b0;
      else if (fire && ev.start)               epi_q <= 1'b1;
      else if (under_i && (zdis_i || fire))    epi_q <= 1'b0;
    end
  end

  assign req_o      = req_q;
  assign req_time_o = time_q;
  assign sw_busy_o  = sw_q;
endmodule

// File: rtl/fdx_pause_trig.sv
module fdx_pause_trig
  import fdx_pause_pkg::*;
#(
  parameter int unsigned LVL_W = 14,
  parameter int unsigned RLD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_duplex_i,
  input  logic             tx_fc_en_i,
  input  logic             sw_send_i,
  output logic             sw_busy_o,
  input  logic [PT_W-1:0]  pause_time_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [LVL_W-1:0] thr_on_i,
  input  logic [LVL_W-1:0] thr_off_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             slot_tick_i,
  input  logic             zero_pause_dis_i,
  output logic             pause_req_o,
  output logic [PT_W-1:0]  pause_time_o,
  input  logic             pause_ack_i
);
  logic en, over, under, expired, accept, accept_nz;

  assign en = full_duplex_i && tx_fc_en_i;

  fdx_pause_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level_i  (fifo_level_i),
    .thr_on_i (thr_on_i),
    .thr_off_i(thr_off_i),
    .over_o   (over),
    .under_o  (under)
  );

  fdx_pause_timer #(.RLD_W(RLD_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .load_i    (accept),
    .load_run_i(accept_nz),
    .reload_i  (reload_i),
    .tick_i    (slot_tick_i),
    .expired_o (expired)
  );

  fdx_pause_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .sw_set_i    (sw_send_i),
    .ack_i       (pause_ack_i),
    .over_i      (over),
    .under_i     (under),
    .expired_i   (expired),
    .zdis_i      (zero_pause_dis_i),
    .pause_time_i(pause_time_i),
    .req_o       (pause_req_o),
    .req_time_o  (pause_time_o),
    .sw_busy_o   (sw_busy_o),
    .accept_o    (accept),
    .accept_nz_o (accept_nz)
  );
endmodule

// File: rtl/fdx_pause_chk.sv
module fdx_pause_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        full_duplex_i,
  input logic        tx_fc_en_i,
  input logic        sw_send_i,
  input logic        sw_busy_o,
  input logic [15:0] pause_time_i,
  input logic        zero_pause_dis_i,
  input logic        pause_req_o,
  input logic [15:0] pause_time_o,
  input logic        pause_ack_i
);
  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o && !pause_ack_i |=> pause_req_o && $stable(pause_time_o));

  assert_req_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o && pause_ack_i |=> !pause_req_o);

  assert_no_new_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_duplex_i && tx_fc_en_i) && !pause_req_o |=> !pause_req_o);

  assert_busy_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_busy_o && !(full_duplex_i && tx_fc_en_i && sw_send_i) |=> !sw_busy_o);

  assert_busy_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_busy_o && !(pause_req_o && pause_ack_i) |=> sw_busy_o);

  assert_no_zero_when_dis_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_req_o && !sw_busy_o && zero_pause_dis_i |=>
      !pause_req_o || pause_time_o == $past(pause_time_i));
endmodule

bind fdx_pause_trig fdx_pause_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .full_duplex_i   (full_duplex_i),
  .tx_fc_en_i      (tx_fc_en_i),
  .sw_send_i       (sw_send_i),
  .sw_busy_o       (sw_busy_o),
  .pause_time_i    (pause_time_i),
  .zero_pause_dis_i(zero_pause_dis_i),
  .pause_req_o     (pause_req_o),
  .pause_time_o    (pause_time_o),
  .pause_ack_i     (pause_ack_i)
);

// File: tb/sim_fdx_pause_trig.sv
`timescale 1ns/1ps
module sim_fdx_pause_trig;
  localparam int LVL_W = 14;
  localparam int RLD_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fd = 1'b0, fcen = 1'b1, sw = 1'b0, slot = 1'b0, zdis = 1'b0, ack = 1'b0;
  logic [15:0]      pt = 16'h0;
  logic [LVL_W-1:0] lvl = '0, hi = 14'd100, lo = 14'd20;
  logic [RLD_W-1:0] rld = 16'd3;
  logic             busy, req;
  logic [15:0]      ptime;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fdx_pause_trig #(.LVL_W(LVL_W), .RLD_W(RLD_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .full_duplex_i(fd), .tx_fc_en_i(fcen),
    .sw_send_i(sw), .sw_busy_o(busy), .pause_time_i(pt), .fifo_level_i(lvl),
    .thr_on_i(hi), .thr_off_i(lo), .reload_i(rld), .slot_tick_i(slot),
    .zero_pause_dis_i(zdis), .pause_req_o(req), .pause_time_o(ptime),
    .pause_ack_i(ack)
  );

  // reference model state
  bit          m_sw, m_req, m_rsw, m_epi, m_run;
  logic [15:0] m_time;
  logic [RLD_W-1:0] m_cnt;

  always @(posedge clk) begin
    bit en, ov, un, acc, exp_t, st, rf, rz, iss;
    if (!rst_n) begin
      m_sw = 0; m_req = 0; m_rsw = 0; m_epi = 0; m_run = 0; m_time = 0; m_cnt = 0;
    end else begin
      en = fd && fcen;
      ov = lvl > hi;
      un = lvl < lo;
      acc = m_req && ack;
      exp_t = m_run && m_cnt == 0;
      st = !m_epi && ov;
      rf = m_epi && exp_t && ov;
      rz = m_epi && un && !zdis;
      iss = en && !m_req && (m_sw || st || rf || rz);
      // timer
      if (!en) m_run = 0;
      else if (acc) begin m_run = (m_time != 0); m_cnt = rld; end
      else if (slot && m_run && m_cnt != 0) m_cnt = m_cnt - 1;
      // episode
      if (!en) m_epi = 0;
      else if (iss && st) m_epi = 1;
      else if (un && (zdis || iss)) m_epi = 0;
      // request
      if (iss) begin
        m_time = (m_sw || st || rf) ? pt : 16'h0;
        m_rsw = m_sw;
        m_req = 1;
      end else if (acc) m_req = 0;
      // software strike, uses pre-edge m_rsw only via acc ordering below
      if (en && sw) m_sw = 1;
      else if (acc && !iss && m_rsw) m_sw = 0;
      else if (acc && iss) m_sw = m_sw; // cannot happen: iss needs !m_req
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req == m_req, "R2/R4/R6/R7/R8 pause_req_o", req, m_req);
      if (m_req) chk(ptime == m_time, "R3/R6/R8/R9 pause_time_o", ptime, m_time);
      chk(busy == m_sw, "R3/R5 sw_busy_o", busy, m_sw);
    end
  end

  task automatic tk(); @(negedge clk); endtask

  task automatic wrap();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    wrap();
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (4) tk();
    chk(req == 0, "R1 req after reset", req, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    rst_n = 1'b1;
    tk();
    // R2: disabled
    fd = 0; sw = 1; lvl = 14'd101; tk(); sw = 0;
    repeat (3) tk();
    chk(req == 0, "R2 no req while disabled", req, 0);
    chk(busy == 0, "R2 strike ignored", busy, 0);
    // R6 then R9 coincidence
    fd = 1; pt = 16'h1234; tk();
    chk(req == 1 && ptime == 16'h1234, "R6 auto start", {req, ptime}, {1'b1, 16'h1234});
    sw = 1; pt = 16'h00AB; lvl = 14'd10; tk(); sw = 0;
    chk(busy == 1, "R3 busy set", busy, 1);
    chk(req == 1 && ptime == 16'h1234, "R4 held", {req, ptime}, {1'b1, 16'h1234});
    ack = 1; tk(); ack = 0;
    chk(req == 0, "R4 drop after ack", req, 0);
    tk();
    chk(req == 1 && ptime == 16'h00AB, "R9 single sw-timed req", {req, ptime}, {1'b1, 16'h00AB});
    ack = 1; tk(); ack = 0;
    chk(busy == 0, "R5 busy cleared", busy, 0);
    repeat (4) tk();
    chk(req == 0, "R9 release consumed", req, 0);
    // R8 zero release
    lvl = 14'd101; tk();
    chk(req == 1 && ptime == 16'h00AB, "R6 episode start", {req, ptime}, {1'b1, 16'h00AB});
    ack = 1; tk(); ack = 0;
    lvl = 14'd10; tk();
    chk(req == 1 && ptime == 16'h0, "R8 zero release", {req, ptime}, {1'b1, 16'h0});
    ack = 1; tk(); ack = 0;
    repeat (3) tk();
    chk(req == 0, "R8 one release only", req, 0);
    // R8 suppressed
    zdis = 1; lvl = 14'd101; tk();
    chk(req == 1, "R6 start again", req, 1);
    ack = 1; tk(); ack = 0;
    lvl = 14'd10; repeat (3) tk();
    chk(req == 0, "R8 suppressed zero", req, 0);
    zdis = 0; repeat (2) tk();
    chk(req == 0, "R8 episode closed", req, 0);
    // R7 refresh
    rld = 16'd2; lvl = 14'd101; tk();
    chk(req == 1, "R6 start for refresh", req, 1);
    ack = 1; tk(); ack = 0;
    repeat (5) tk();
    chk(req == 0, "R7 waits for slots", req, 0);
    slot = 1; tk(); tk(); slot = 0;
    chk(req == 0, "R7 expiry edge", req, 0);
    tk();
    chk(req == 1 && ptime == 16'h00AB, "R7 refresh", {req, ptime}, {1'b1, 16'h00AB});
    ack = 1; tk(); ack = 0;
    // R3 zero-time strike
    lvl = 14'd50; pt = 16'h0; sw = 1; tk(); sw = 0;
    chk(busy == 1, "R3 busy zero strike", busy, 1);
    tk();
    chk(req == 1 && ptime == 16'h0, "R3 zero-time strike", {req, ptime}, {1'b1, 16'h0});
    ack = 1; tk(); ack = 0;
    chk(busy == 0 && req == 0, "R5 cleared after zero ack", {busy, req}, 0);
    // random phase
    for (int blk = 0; blk < 40; blk++) begin
      fd   = ($urandom % 8) != 0;
      fcen = ($urandom % 16) != 0;
      zdis = $urandom % 2;
      hi   = 14'(60 + $urandom % 80);
      lo   = 14'(10 + $urandom % 40);
      rld  = 16'($urandom % 6);
      for (int c = 0; c < 500; c++) begin
        if ($urandom % 8 == 0) lvl = 14'($urandom % 200);
        if ($urandom % 16 == 0) pt = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
        sw   = ($urandom % 64) == 0;
        slot = $urandom % 2;
        ack  = ($urandom % 3) == 0;
        tk();
      end
    end
    sw = 0; ack = 0; slot = 0;
    tk();
    wrap();
  end
endmodule